// File: doc/BRIEF.md
# Three-wire synchronous serial port

This block moves one byte at a time over a clock line, a data-out line and a data-in line. A single mode register switches the port on and off, chooses whether the least or the most significant bit travels first, and selects the shift clock. The clock can be one of three divided copies of the system clock, or a clock that an external master applies to the clock pin. While the port is off, the mode register also decides whether the clock pin is forced high or handed back to general-purpose port logic.

Software writes a byte to the data register while the port is on, and the transfer starts. Eight serial clocks later the block raises a one-cycle completion pulse, and the received byte can be read from the same register. The pin side is given as output values, output enables and "released to port" flags, which the surrounding pad logic uses to multiplex each pin. A separate receive-enable input selects transmit-only operation. The automatic multi-byte mode bit is held in the register and read back, but it has no effect.

Top module: `serial3w_port`

## Requirements
- R1: After reset the mode register reads 0x00, `xfer_done` is 0, and `sck_port`, `so_port` and `si_port` are 1 while `sck_oe` and `so_oe` are 0.
- R2: The mode register (address 0) holds on[7], lsb_first[6], auto[5], clock-pin hold[4] and clock select[1:0]. Bits 3:2 always read as 0.
- R3: While on[7]=0 no transfer runs and `so_port`=`si_port`=1. With hold=1 the clock pin is driven high (`sck_oe`=1, `sck_o`=1, `sck_port`=0). With hold=0 the clock pin is released (`sck_oe`=0, `sck_port`=1).
- R4: A write to the data register (address 1) while on=1 and no transfer is running starts an 8-bit transfer. A data write during a running transfer is ignored. A data write while off loads the register and starts nothing.
- R5: Clock select 01, 10 and 11 give a serial clock period of 4, 8 and 16 system clocks. The clock idles high. In these modes the pin is driven (`sck_oe`=1) whatever the hold bit holds.
- R6: `so_o` changes only on a falling serial clock edge. The data-in line is sampled on the rising edge.
- R7: lsb_first=0 sends and receives the most significant bit first. lsb_first=1 sends and receives the least significant bit first.
- R8: Clock select 00 takes the shift clock from `sck_i` through a two-stage synchronizer. The clock pin is then an input (`sck_oe`=0, `sck_port`=0).
- R9: One cycle after the eighth rising serial edge, `xfer_done` pulses high for exactly one cycle, and the received byte reads back from address 1.
- R10: With `rx_en`=0, `si_port` is 1 and 0 is shifted in instead of the data-in pin, so a completed transfer reads back 0x00.
- R11: Clearing on during a transfer aborts it at once, with no completion pulse. The next transfer then runs a full eight bits.
- R12: The auto bit is stored and read back, and has no effect on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mode, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| rx_en | input | 1 | Receive enable; 0 gives transmit-only operation |
| xfer_done | output | 1 | One-cycle transfer completion pulse |
| sck_i | input | 1 | Clock pin input value |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sck_port | output | 1 | Clock pin released to general port use |
| so_o | output | 1 | Data-out pin value |
| so_oe | output | 1 | Data-out pin output enable |
| so_port | output | 1 | Data-out pin released to general port use |
| si_i | input | 1 | Data-in pin value |
| si_port | output | 1 | Data-in pin released to general port use |

## Verification
The bench aims at three kinds of error. A design that counts the clock divider one cycle short or long would put every serial edge in the wrong cycle. A design that moves `so_o` on the rising edge would change the data while the partner samples it. A design that leaves the bit counter running after an abort would end the next transfer early. A further test writes to the data register during a transfer: a design that restarts there, or that overwrites the shift register, sends a different byte. Transmit-only runs and both bit orders are checked through the received byte. Externally clocked runs check that the synchronized pin clock, not the internal divider, drives the shifting.

// File: rtl/serial3w_pkg.sv
package serial3w_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CK_EXT   = 2'b00,
    CK_DIV4  = 2'b01,
    CK_DIV8  = 2'b10,
    CK_DIV16 = 2'b11
  } cksel_e;

  typedef struct packed {
    logic   on;
    logic   lsb_first;
    logic   auto_md;
    logic   pin_hold;
    cksel_e cksel;
  } mode_t;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

endpackage

// File: rtl/serial3w_clkgen.sv
module serial3w_clkgen
  import serial3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned HALF_LOG2_MIN = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  cksel_e cksel,
  input  logic   sck_pin_i,
  output logic   sck_q_o,
  output logic   fall_ev_o,
  output logic   rise_ev_o
);

  localparam int unsigned CNT_W = HALF_LOG2_MIN + 3;

  logic [CNT_W-1:0]     cnt_q, cnt_d, half_m1;
  logic                 sck_q, sck_d;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext, tick, pin_now, pin_prev;

  assign ext = (cksel == CK_EXT);

  always_comb begin
    unique case (cksel)
      CK_DIV4:  half_m1 = CNT_W'((1 << HALF_LOG2_MIN) - 1);
      CK_DIV8:  half_m1 = CNT_W'((1 << (HALF_LOG2_MIN + 1)) - 1);
      CK_DIV16: half_m1 = CNT_W'((1 << (HALF_LOG2_MIN + 2)) - 1);
      default:  half_m1 = '0;
    endcase
  end

  assign tick = run && !ext && (cnt_q == half_m1);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run || ext) begin
      cnt_d = '0;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = !sck_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= '1;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      sync_q <= {sync_q[SYNC_STAGES-1:0], sck_pin_i};
    end
  end

  assign pin_now  = sync_q[SYNC_STAGES-1];
  assign pin_prev = sync_q[SYNC_STAGES];

  assign sck_q_o   = sck_q;
  assign fall_ev_o = (tick && sck_q)  || (run && ext && pin_prev && !pin_now);
  assign rise_ev_o = (tick && !sck_q) || (run && ext && !pin_prev && pin_now);

endmodule

// File: rtl/serial3w_shifter.sv
module serial3w_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on,
  input  logic          lsb_first,
  input  logic          rx_en,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          si_i,
  input  logic          fall_ev,
  input  logic          rise_ev,
  output logic          busy_o,
  output logic          done_o,
  output logic          so_o,
  output logic [DW-1:0] data_o
);

  localparam int unsigned CNT_W = $clog2(DW);

  logic [DW-1:0]    sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d, so_q, so_d, in_bit;

  assign in_bit = rx_en && si_i;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    so_d   = so_q;
    if (!on) begin
      cnt_d  = '0;
      busy_d = 1'b0;
      if (load) sr_d = wdata;
    end else if (!busy_q) begin
      if (load) begin
        sr_d   = wdata;
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else begin
      if (fall_ev) so_d = lsb_first ? sr_q[0] : sr_q[DW-1];
      if (rise_ev) begin
        sr_d = lsb_first ? {in_bit, sr_q[DW-1:1]} : {sr_q[DW-2:0], in_bit};
        if (cnt_q == CNT_W'(DW - 1)) begin
          cnt_d  = '0;
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      so_q   <= so_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign so_o   = so_q;
  assign data_o = sr_q;

endmodule

// File: rtl/serial3w_port.sv
module serial3w_port
  import serial3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned HALF_LOG2_MIN = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_en,
  output logic        xfer_done,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe,
  output logic        sck_port,
  output logic        so_o,
  output logic        so_oe,
  output logic        so_port,
  input  logic        si_i,
  output logic        si_port
);

  mode_t              mode_q, mode_d;
  logic               mode_we, data_we;
  logic               mode_en;
  cksel_e             mode_cs;
  logic               busy, sck_int, fall_ev, rise_ev, so_bit;
  logic [BYTE_W-1:0]  shift_data;

  assign mode_we = bus_wr && (bus_addr == ADDR_MODE);
  assign data_we = bus_wr && (bus_addr == ADDR_DATA);

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d.on        = bus_wdata[7];
      mode_d.lsb_first = bus_wdata[6];
      mode_d.auto_md   = bus_wdata[5];
      mode_d.pin_hold  = bus_wdata[4];
      mode_d.cksel     = cksel_e'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode_en = mode_q.on;
  assign mode_cs = mode_q.cksel;

  serial3w_clkgen #(
    .SYNC_STAGES  (SYNC_STAGES),
    .HALF_LOG2_MIN(HALF_LOG2_MIN)
  ) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .cksel    (mode_q.cksel),
    .sck_pin_i(sck_i),
    .sck_q_o  (sck_int),
    .fall_ev_o(fall_ev),
    .rise_ev_o(rise_ev)
  );

  serial3w_shifter #(.DW(BYTE_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .on       (mode_d.on),
    .lsb_first(mode_q.lsb_first),
    .rx_en    (rx_en),
    .load     (data_we),
    .wdata    (bus_wdata),
    .si_i     (si_i),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .busy_o   (busy),
    .done_o   (xfer_done),
    .so_o     (so_bit),
    .data_o   (shift_data)
  );

  always_comb begin
    if (bus_addr == ADDR_MODE)
      bus_rdata = {mode_q.on, mode_q.lsb_first, mode_q.auto_md, mode_q.pin_hold,
                   2'b00, mode_q.cksel};
    else
      bus_rdata = shift_data;
  end

  always_comb begin
    if (mode_q.on) begin
      sck_o    = sck_int;
      sck_oe   = (mode_q.cksel != CK_EXT);
      sck_port = 1'b0;
    end else begin
      sck_o    = 1'b1;
      sck_oe   = mode_q.pin_hold;
      sck_port = !mode_q.pin_hold;
    end
  end

  assign so_o    = so_bit;
  assign so_oe   = mode_q.on;
  assign so_port = !mode_q.on;
  assign si_port = !mode_q.on || !rx_en;

endmodule

// File: rtl/serial3w_port_chk.sv
module serial3w_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] cs,
  input logic       busy,
  input logic       done,
  input logic       sck_o,
  input logic       so_o,
  input logic       so_oe,
  input logic       so_port,
  input logic       si_port,
  input logic       rx_en,
  input logic       addr,
  input logic [7:0] rdata
);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_off_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !busy);

  a_r3_off_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (so_port && si_port && !so_oe));

  a_r5_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cs != 2'b00 && !busy && !$past(busy)) |-> sck_o);

  a_r6_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cs != 2'b00 && $stable(cs) && !$fell(sck_o)) |-> $stable(so_o));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 1'b0) |-> (rdata[3:2] == 2'b00));

  a_r10_rx_off_port: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> si_port);

endmodule

bind serial3w_port serial3w_port_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (mode_en),
  .cs     (mode_cs),
  .busy   (busy),
  .done   (xfer_done),
  .sck_o  (sck_o),
  .so_o   (so_o),
  .so_oe  (so_oe),
  .so_port(so_port),
  .si_port(si_port),
  .rx_en  (rx_en),
  .addr   (bus_addr),
  .rdata  (bus_rdata)
);

// File: tb/sim_serial3w_port.sv
`timescale 1ns/1ps
module sim_serial3w_port;

  logic       clk, rst_n;
  logic       bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_en, xfer_done;
  logic       sck_i, sck_o, sck_oe, sck_port;
  logic       so_o, so_oe, so_port, si_i, si_port;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  // reference model state
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_tx = 8'h00;
  logic [7:0] m_rx = 8'h00;
  bit         m_busy = 0;
  int         m_t = 0;
  int         m_half = 2;
  bit         e_done = 0;
  bit         ext_drive = 0;
  logic       ext_si = 1'b0;
  logic       int_si = 1'b0;

  assign si_i = ext_drive ? ext_si : int_si;

  serial3w_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_en(rx_en),
    .xfer_done(xfer_done), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_port(sck_port), .so_o(so_o), .so_oe(so_oe), .so_port(so_port),
    .si_i(si_i), .si_port(si_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit int_mode();
    return m_mode[7] && (m_mode[1:0] != 2'b00);
  endfunction

  // behavioural model, updated on the same edge as the design
  always @(posedge clk) begin
    bit was_busy;
    e_done = 0;
    if (!rst_n) begin
      m_mode = 8'h00; m_busy = 0; m_t = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == 16 * m_half) begin m_busy = 0; e_done = 1; end
      end
      if (bus_wr && bus_addr == 1'b0) begin
        m_mode = bus_wdata;
        if (!bus_wdata[7]) m_busy = 0;
      end else if (bus_wr && bus_addr == 1'b1 && !was_busy && int_mode()) begin
        m_busy = 1; m_t = 0; m_tx = bus_wdata; m_half = 1 << m_mode[1:0];
      end
    end
  end

  always @(posedge clk) if (rst_n && xfer_done) done_cnt++;

  // data-in drive and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int k, j;
    bit exp_sck, exp_so;
    int_si = 1'b0;
    if (m_busy) begin
      k = m_t / m_half;
      if (k % 2 == 1) begin
        j = (k - 1) / 2;
        int_si = m_mode[6] ? m_rx[j] : m_rx[7 - j];
      end
    end
    if (rst_n && int_mode()) begin
      k = m_busy ? m_t / m_half : 0;
      exp_sck = (k % 2 == 0);
      chk(sck_o == exp_sck, "R5 R6 clock level", sck_o, exp_sck);
      chk(sck_oe == 1'b1, "R5 clock driven", sck_oe, 1);
      chk(xfer_done == e_done, "R9 done timing", xfer_done, e_done);
      if (m_busy && k >= 1) begin
        j = (k - 1) / 2;
        exp_so = m_mode[6] ? m_tx[j] : m_tx[7 - j];
        chk(so_o == exp_so, "R6 R7 data out", so_o, exp_so);
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_int(input logic [7:0] mode, input logic [7:0] tx, input logic [7:0] rx,
                         input logic rxe, input bit poke, input string tag);
    int d0, n;
    logic [7:0] v, exp;
    wr(1'b0, mode);
    rx_en = rxe;
    m_rx = rx;
    d0 = done_cnt;
    wr(1'b1, tx);
    if (poke) begin
      repeat (10) @(negedge clk);
      wr(1'b1, ~tx);
    end
    n = 0;
    while (m_busy && n < 600) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " one completion"}, done_cnt - d0, 1);
    rd(1'b1, v);
    exp = rxe ? rx : 8'h00;
    chk(v == exp, {tag, " received byte"}, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    int d0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    rx_en = 1'b1; sck_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v);
    chk(v == 8'h00, "R1 mode reset", v, 8'h00);
    chk(xfer_done == 1'b0, "R1 done low", xfer_done, 0);
    chk({sck_port, so_port, si_port} == 3'b111, "R1 pins released", {sck_port, so_port, si_port}, 3'b111);
    chk({sck_oe, so_oe} == 2'b00, "R1 no drive", {sck_oe, so_oe}, 2'b00);

    // R2 R12 register fields, reserved bits read zero
    wr(1'b0, 8'h7E);
    rd(1'b0, v);
    chk(v == 8'h72, "R2 R12 mode readback", v, 8'h72);

    // R3 disabled pin behaviour with hold set / clear
    chk(sck_oe && sck_o && !sck_port, "R3 hold drives high", {sck_oe, sck_o, sck_port}, 3'b110);
    wr(1'b0, 8'h01);
    chk(!sck_oe && sck_port, "R3 clock released", {sck_oe, sck_port}, 2'b01);
    // R4 data write while off: loaded, nothing starts
    d0 = done_cnt;
    wr(1'b1, 8'h5A);
    repeat (60) @(negedge clk);
    rd(1'b1, v);
    chk(v == 8'h5A, "R4 load while off", v, 8'h5A);
    chk(done_cnt == d0, "R4 R3 no transfer while off", done_cnt - d0, 0);
    chk(so_port && si_port && !so_oe, "R3 data pins released", {so_port, si_port, so_oe}, 3'b110);

    // R5 R7 R9 internal clock, all dividers, both orders
    run_int(8'h81, 8'hA5, 8'h3C, 1'b1, 0, "R9 R7 div4 msb");
    run_int(8'hC2, 8'h96, 8'hE1, 1'b1, 0, "R9 R7 div8 lsb");
    run_int(8'h93, 8'h0F, 8'hB4, 1'b1, 0, "R9 R5 div16 hold");
    run_int(8'hE1, 8'h81, 8'h7E, 1'b1, 0, "R12 auto no effect");
    // R4 write during transfer ignored
    run_int(8'h82, 8'hC3, 8'h5D, 1'b1, 1, "R4 busy write");
    // R10 transmit only
    rx_en = 1'b0;
    @(negedge clk);
    chk(si_port == 1'b1, "R10 data-in released", si_port, 1);
    run_int(8'h81, 8'h3A, 8'hFF, 1'b0, 0, "R10 transmit only");
    rx_en = 1'b1;

    // R11 abort mid transfer, then a full transfer
    wr(1'b0, 8'h93);
    m_rx = 8'h66;
    d0 = done_cnt;
    wr(1'b1, 8'h55);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'h13);
    chk(sck_o && sck_oe, "R11 R3 clock high after abort", {sck_o, sck_oe}, 2'b11);
    repeat (200) @(negedge clk);
    chk(done_cnt == d0, "R11 no completion on abort", done_cnt - d0, 0);
    run_int(8'h93, 8'hCA, 8'h99, 1'b1, 0, "R11 full after abort");

    // R8 external clock, msb then lsb first
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] tx, rx;
      bit eb;
      tx = pass ? 8'h2D : 8'hB1;
      rx = pass ? 8'hC6 : 8'h4B;
      wr(1'b0, pass ? 8'hC0 : 8'h80);
      chk(!sck_oe && !sck_port, "R8 clock pin input", {sck_oe, sck_port}, 2'b00);
      ext_drive = 1;
      d0 = done_cnt;
      wr(1'b1, tx);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        sck_i = 1'b0;
        ext_si = pass ? rx[j] : rx[7 - j];
        repeat (8) @(negedge clk);
        eb = pass ? tx[j] : tx[7 - j];
        chk(so_o == eb, "R8 R7 external data out", so_o, eb);
        sck_i = 1'b1;
        repeat (8) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(done_cnt == d0 + 1, "R8 R9 external completion", done_cnt - d0, 1);
      rd(1'b1, v);
      chk(v == rx, "R8 external received", v, rx);
      ext_drive = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired act=%0d exp=0", 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule